// File: doc/BRIEF.md
# Processor Status Word Unit

This block keeps the status word of a small processor: the flags that an 8-bit add or subtract produces, an interrupt-enable bit and a register-bank select bit. The arithmetic path is a single-beat transfer. When `op_valid` is high on a rising clock edge, the unit adds or subtracts `op_a` and `op_b`. The registered result and its four flags appear after that edge. The unit never applies back-pressure: every beat is taken in the cycle it is offered, so no ready signal exists, and a beat that is not presented leaves the flags untouched.

The interrupt side is plain control. EI and DI command strobes and an acknowledge strobe set or clear the enable bit. The unit gates a maskable interrupt request with that bit and passes a non-maskable request straight through. The register-bank select bit changes only through its own write strobe. Reset is synchronous and active high, and it clears every stored bit.

Top module: `status_word_unit`

## Requirements
- R1: After a synchronous reset, `result`, every flag, `ie`, `rss` and `psw` read 0.
- R2: On an accepted add (`op_sub`=0), `result` is (`op_a`+`op_b`) mod 256 and `flag_cy` is the carry out of bit 7; for example 0xFB+0xF0 gives 0xEB with carry 1.
- R3: `flag_ov` is 1 when the signed result of the accepted operation lies outside -128..127. For example, 0x78+0x69 gives 0xE1 with overflow 1 and carry 0, and 0xFB+0xF0 gives overflow 0.
- R4: On an accepted subtract (`op_sub`=1), `result` is (`op_a`-`op_b`) mod 256 and `flag_cy` is 1 exactly when a borrow leaves bit 7 (`op_a` < `op_b` unsigned).
- R5: `flag_ac` is 1 when an add carries out of bit 3, or when a subtract borrows into bit 3 (low nibble of `op_a` below low nibble of `op_b`). Otherwise it is 0.
- R6: After an accepted operation, `flag_z` is 1 exactly when `result` is 0.
- R7: In a cycle where `op_valid` is 0, `result` and the four arithmetic flags keep their values.
- R8: `cmd_ei` sets `ie` on the next edge and `cmd_di` clears it; if both are high, DI wins.
- R9: `int_ack` clears `ie` on the next edge, even when `cmd_ei` is high in the same cycle.
- R10: `mreq_out` equals `mreq_in` AND `ie`; `nmi_out` always equals `nmi_in`.
- R11: `rss` takes `rss_wdata` on an edge where `rss_we` is 1 and otherwise holds; arithmetic and interrupt strobes do not change it.
- R12: `psw` packs the state as bit0 CY, bit1 OV, bit2 AC, bit3 Z, bit4 RSS, bit5 IE, bits 7:6 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Arithmetic beat present; always accepted |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_a | input | 8 | First operand / minuend |
| op_b | input | 8 | Second operand / subtrahend |
| result | output | 8 | Registered result of the last accepted beat |
| flag_cy | output | 1 | Carry / borrow out of bit 7 |
| flag_ov | output | 1 | Signed overflow |
| flag_ac | output | 1 | Carry out of / borrow into bit 3 |
| flag_z | output | 1 | Result is zero |
| cmd_ei | input | 1 | Enable-interrupts command strobe |
| cmd_di | input | 1 | Disable-interrupts command strobe |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| rss_we | input | 1 | Write strobe for the bank select bit |
| rss_wdata | input | 1 | Value written to the bank select bit |
| rss | output | 1 | Register-bank select bit |
| ie | output | 1 | Interrupt-enable bit |
| mreq_in | input | 1 | Pending maskable request |
| nmi_in | input | 1 | Non-maskable request |
| mreq_out | output | 1 | Gated maskable request |
| nmi_out | output | 1 | Non-maskable request, passed through |
| psw | output | 8 | Packed status word |

## Verification
The arithmetic path is driven with the two signed-overflow cases, positive plus positive and negative plus negative. These separate overflow from carry, because each case sets one flag and not the other. Subtracts with mixed signs, equal operands and nibble-only borrows separate the borrow-into-bit-3 rule from the bit-7 borrow and from the zero flag. Long random runs with sparse `op_valid` expose flags that change without a beat. Collisions of EI with DI and of EI with acknowledge confirm which strobe wins, and the request gating is compared in every cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int DW = 8;
  localparam int PSW_CY  = 0;
  localparam int PSW_OV  = 1;
  localparam int PSW_AC  = 2;
  localparam int PSW_Z   = 3;
  localparam int PSW_RSS = 4;
  localparam int PSW_IE  = 5;

  typedef struct packed {
    logic cy;
    logic ov;
    logic ac;
    logic z;
  } arith_flags_t;
endpackage

// File: rtl/psw_arith.sv
module psw_arith
  import psw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output arith_flags_t flg
);
  localparam int NIB = W / 2;

  logic [W:0]   wide;
  logic [NIB:0] low;

  always_comb begin
    if (sub) begin
      wide = {1'b0, a} - {1'b0, b};
      low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]};
    end else begin
      wide = {1'b0, a} + {1'b0, b};
      low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
    end
    res    = wide[W-1:0];
    flg.cy = wide[W];
    flg.ac = low[NIB];
    flg.z  = (wide[W-1:0] == '0);
    if (sub)
      flg.ov = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]);
    else
      flg.ov = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/psw_intctl.sv
module psw_intctl (
  input  logic clk,
  input  logic rst,
  input  logic cmd_ei,
  input  logic cmd_di,
  input  logic int_ack,
  input  logic mreq_in,
  input  logic nmi_in,
  output logic ie,
  output logic mreq_out,
  output logic nmi_out
);
  always_ff @(posedge clk) begin
    if (rst)                    ie <= 1'b0;
    else if (int_ack || cmd_di) ie <= 1'b0;
    else if (cmd_ei)            ie <= 1'b1;
  end

  assign mreq_out = mreq_in & ie;
  assign nmi_out  = nmi_in;
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
  import psw_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          op_sub,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic [DW-1:0] result,
  output logic          flag_cy,
  output logic          flag_ov,
  output logic          flag_ac,
  output logic          flag_z,
  input  logic          cmd_ei,
  input  logic          cmd_di,
  input  logic          int_ack,
  input  logic          rss_we,
  input  logic          rss_wdata,
  output logic          rss,
  output logic          ie,
  input  logic          mreq_in,
  input  logic          nmi_in,
  output logic          mreq_out,
  output logic          nmi_out,
  output logic [7:0]    psw
);
  logic [DW-1:0] nxt_res;
  arith_flags_t  nxt_flg;
  arith_flags_t  flg_q;

  psw_arith #(.W(DW)) u_arith (
    .sub (op_sub),
    .a   (op_a),
    .b   (op_b),
    .res (nxt_res),
    .flg (nxt_flg)
  );

  psw_intctl u_int (
    .clk      (clk),
    .rst      (rst),
    .cmd_ei   (cmd_ei),
    .cmd_di   (cmd_di),
    .int_ack  (int_ack),
    .mreq_in  (mreq_in),
    .nmi_in   (nmi_in),
    .ie       (ie),
    .mreq_out (mreq_out),
    .nmi_out  (nmi_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flg_q  <= '0;
    end else if (op_valid) begin
      result <= nxt_res;
      flg_q  <= nxt_flg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rss <= 1'b0;
    else if (rss_we) rss <= rss_wdata;
  end

  assign flag_cy = flg_q.cy;
  assign flag_ov = flg_q.ov;
  assign flag_ac = flg_q.ac;
  assign flag_z  = flg_q.z;

  always_comb begin
    psw          = '0;
    psw[PSW_CY]  = flg_q.cy;
    psw[PSW_OV]  = flg_q.ov;
    psw[PSW_AC]  = flg_q.ac;
    psw[PSW_Z]   = flg_q.z;
    psw[PSW_RSS] = rss;
    psw[PSW_IE]  = ie;
  end
endmodule

// File: rtl/psw_checker.sv
module psw_checker (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic       op_sub,
  input logic [7:0] op_a,
  input logic [7:0] op_b,
  input logic [7:0] result,
  input logic       flag_cy,
  input logic       flag_ov,
  input logic       flag_ac,
  input logic       flag_z,
  input logic       cmd_ei,
  input logic       cmd_di,
  input logic       int_ack,
  input logic       rss_we,
  input logic       rss,
  input logic       ie,
  input logic       mreq_out,
  input logic       nmi_in,
  input logic       nmi_out
);
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    op_valid && !op_sub |=> {flag_cy, result} == ($past({1'b0, op_a}) + $past({1'b0, op_b}))); // R2
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> flag_z == (result == 8'h00)); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable({result, flag_cy, flag_ov, flag_ac, flag_z})); // R7
  AST_EI_SETS: assert property (@(posedge clk) disable iff (rst)
    cmd_ei && !cmd_di && !int_ack |=> ie); // R8
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd_di |=> !ie); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !ie); // R9
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
    !ie |-> !mreq_out); // R10
  AST_NMI_PASS: assert property (@(posedge clk) disable iff (rst)
    nmi_out == nmi_in); // R10
  AST_RSS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rss_we |=> $stable(rss)); // R11
endmodule

bind status_word_unit psw_checker u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sub(op_sub),
  .op_a(op_a), .op_b(op_b), .result(result), .flag_cy(flag_cy),
  .flag_ov(flag_ov), .flag_ac(flag_ac), .flag_z(flag_z),
  .cmd_ei(cmd_ei), .cmd_di(cmd_di), .int_ack(int_ack), .rss_we(rss_we),
  .rss(rss), .ie(ie), .mreq_out(mreq_out), .nmi_in(nmi_in), .nmi_out(nmi_out)
);

// File: tb/tb_status_word_unit.sv
`timescale 1ns/1ps
module tb_status_word_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 0, op_sub = 0;
  logic [7:0] op_a = 0, op_b = 0;
  logic cmd_ei = 0, cmd_di = 0, int_ack = 0, rss_we = 0, rss_wdata = 0;
  logic mreq_in = 0, nmi_in = 0;
  logic [7:0] result, psw;
  logic flag_cy, flag_ov, flag_ac, flag_z, rss, ie, mreq_out, nmi_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_res = 0, m_cy = 0, m_ov = 0, m_ac = 0, m_z = 0, m_ie = 0, m_rss = 0;

  always #10 clk = ~clk;

  status_word_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sub(op_sub),
    .op_a(op_a), .op_b(op_b), .result(result), .flag_cy(flag_cy),
    .flag_ov(flag_ov), .flag_ac(flag_ac), .flag_z(flag_z),
    .cmd_ei(cmd_ei), .cmd_di(cmd_di), .int_ack(int_ack),
    .rss_we(rss_we), .rss_wdata(rss_wdata), .rss(rss), .ie(ie),
    .mreq_in(mreq_in), .nmi_in(nmi_in), .mreq_out(mreq_out),
    .nmi_out(nmi_out), .psw(psw)
  );

  // Behavioural reference model, integer arithmetic
  always @(posedge clk) begin
    int ua, ub, sa, sb, full, sres, lo;
    if (rst) begin
      m_res <= 0; m_cy <= 0; m_ov <= 0; m_ac <= 0; m_z <= 0; m_ie <= 0; m_rss <= 0;
    end else begin
      if (op_valid) begin
        ua = op_a; ub = op_b;
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        if (op_sub) begin
          full = ua - ub; sres = sa - sb; lo = (ua % 16) - (ub % 16);
          m_cy <= (full < 0);
          m_ac <= (lo < 0);
        end else begin
          full = ua + ub; sres = sa + sb; lo = (ua % 16) + (ub % 16);
          m_cy <= (full > 255);
          m_ac <= (lo > 15);
        end
        m_res <= (full + 256) % 256;
        m_z   <= (((full + 256) % 256) == 0);
        m_ov  <= (sres > 127 || sres < -128);
      end
      if (int_ack || cmd_di) m_ie <= 0;
      else if (cmd_ei)       m_ie <= 1;
      if (rss_we) m_rss <= rss_wdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_psw;
    chk("R2/R4 result", result, m_res);
    chk("R2/R4 flag_cy", flag_cy, m_cy);
    chk("R3 flag_ov", flag_ov, m_ov);
    chk("R5 flag_ac", flag_ac, m_ac);
    chk("R6 flag_z", flag_z, m_z);
    chk("R8 ie", ie, m_ie);
    chk("R11 rss", rss, m_rss);
    chk("R10 mreq_out", mreq_out, mreq_in & m_ie);
    chk("R10 nmi_out", nmi_out, nmi_in);
    exp_psw = m_cy + 2*m_ov + 4*m_ac + 8*m_z + 16*m_rss + 32*m_ie;
    chk("R12 psw", psw, exp_psw);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    op_valid = 0; cmd_ei = 0; cmd_di = 0; int_ack = 0; rss_we = 0;
  endtask

  task automatic arith(bit s, int a, int b);
    op_valid = 1; op_sub = s; op_a = a[7:0]; op_b = b[7:0];
    tick();
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; tick(); tick();
    rst = 0;
    // R1: reset state
    chk("R1 psw after reset", psw, 0);
    chk("R1 result after reset", result, 0);

    // R3 positive overflow
    arith(0, 'h78, 'h69);
    chk("R3 result", result, 'hE1); chk("R3 ov", flag_ov, 1); chk("R3 cy", flag_cy, 0);
    // R2 negatives in range
    arith(0, 'hFB, 'hF0);
    chk("R2 result", result, 'hEB); chk("R2 cy", flag_cy, 1); chk("R3 ov clear", flag_ov, 0);
    // R4 subtract borrow and R6 zero
    arith(1, 'h10, 'h20);
    chk("R4 result", result, 'hF0); chk("R4 borrow", flag_cy, 1);
    arith(1, 'h5A, 'h5A);
    chk("R6 zero", flag_z, 1); chk("R4 no borrow", flag_cy, 0);
    // R4 subtract overflow: 0x80 - 0x01
    arith(1, 'h80, 'h01);
    chk("R4 sub ov", flag_ov, 1);
    // R5 nibble borrow only
    arith(1, 'h31, 'h02);
    chk("R5 ac sub", flag_ac, 1); chk("R5 cy sub", flag_cy, 0);
    arith(0, 'h0F, 'h01);
    chk("R5 ac add", flag_ac, 1);
    // R7 hold
    tick();
    chk("R7 hold result", result, 'h10);
    // R8 EI, DI collision
    cmd_ei = 1; tick(); chk("R8 ei sets", ie, 1);
    mreq_in = 1; nmi_in = 1; #1;
    chk("R10 mreq passes", mreq_out, 1); chk("R10 nmi", nmi_out, 1);
    cmd_ei = 1; cmd_di = 1; tick(); chk("R8 di wins", ie, 0);
    chk("R10 mreq blocked", mreq_out, 0);
    cmd_ei = 1; tick();
    // R9 ack beats EI
    cmd_ei = 1; int_ack = 1; tick(); chk("R9 ack wins", ie, 0);
    // R11 rss
    rss_we = 1; rss_wdata = 1; tick(); chk("R11 rss write", rss, 1);
    arith(0, 1, 1); chk("R11 rss unaffected", rss, 1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      op_valid = ($urandom % 3) == 0;
      op_sub = $urandom; op_a = $urandom; op_b = $urandom;
      cmd_ei = ($urandom % 5) == 0; cmd_di = ($urandom % 9) == 0;
      int_ack = ($urandom % 9) == 0;
      rss_we = ($urandom % 7) == 0; rss_wdata = $urandom;
      mreq_in = $urandom; nmi_in = $urandom;
      tick();
    end

    // R1 reset again from busy state
    rst = 1; tick(); rst = 0;
    chk("R1 psw second reset", psw, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule